// File: doc/BRIEF.md
# Two-Phase Processor Clock Generator

This block takes one fast oscillator clock and derives from it the two non-overlapping clock phases that a processor core of the older two-phase kind expects. The phase period is nine oscillator periods, so an 18.432 MHz source gives a phase period of about 488 ns. A shared modulo-nine state counter sets the position of each phase inside that period. The block also outputs a buffered copy of the oscillator and a logic-level copy of phase 2.

Around the phases, the block conditions three control signals. An asynchronous memory-ready input passes through a two-stage synchronizer that advances only at phase-2 rising edges, and its output is the processor's READY. A raw active-low reset request goes through an identical synchronizer and comes out as an active-high processor reset. The processor's SYNC output, sampled while phase 2 is high, makes the block issue a one-oscillator-period active-low status strobe at the start of the next phase 1.

All outputs are registered on the oscillator clock. Every window position, window length and synchronizer depth is a parameter, and elaboration checks that the parameters keep the phases apart.

Top module: `twophase_clkgen`

## Requirements
- R1: `phi1` is high for exactly PH1_LEN (default 2) consecutive oscillator periods, and successive `phi1` rising edges are DIV (default 9) oscillator periods apart.
- R2: `phi2` is high for exactly PH2_LEN (default 5) consecutive oscillator periods. It rises PH2_START (default 3) oscillator periods after each `phi1` rising edge.
- R3: `phi1` and `phi2` are never high together, and each transition between them leaves at least one oscillator period with both low.
- R4: `phi2_ttl` always equals `phi2`, and `osc_out` follows `osc_clk`.
- R5: `ready` changes only at an oscillator edge where `phi2` rises. At such an edge it takes the `rdy_in` level that was sampled at the previous `phi2` rising edge, which gives two synchronizer stages.
- R6: `reset_out` is the inverse of `resin_n`, moved through the same two-stage pipeline as `ready` and updated only where `phi2` rises. While `rst_n` is low, `reset_out` is 1.
- R7: `stat_strobe_n` is low for exactly one oscillator period. That period begins at the `phi1` rising edge, and the strobe fires only if `sync_in` was high at one or more clock edges during the preceding `phi2` high window. In every other case the strobe stays high.
- R8: While `rst_n` is low: `phi1`=0, `phi2`=0, `ready`=0, `reset_out`=1, `stat_strobe_n`=1. The first oscillator edge after `rst_n` rises drives `phi1` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Fast oscillator clock |
| rst_n | input | 1 | Active-low reset of the generator itself |
| rdy_in | input | 1 | Asynchronous memory-ready, high means ready |
| resin_n | input | 1 | Raw active-low processor reset request |
| sync_in | input | 1 | Processor SYNC, marks the first state of a machine cycle |
| osc_out | output | 1 | Buffered oscillator copy |
| phi1 | output | 1 | Processor clock phase 1 |
| phi2 | output | 1 | Processor clock phase 2 |
| phi2_ttl | output | 1 | Logic-level copy of phase 2 |
| ready | output | 1 | Synchronized READY |
| reset_out | output | 1 | Synchronized active-high processor reset |
| stat_strobe_n | output | 1 | Active-low status strobe |

## Verification
The bench keeps a cycle model of the phase position and checks the phases after every oscillator edge. Off-by-one window bounds show up there as a stretched or shortened phase, an overlap, or a phase period other than nine. Random ready and reset toggles catch a synchronizer that runs every oscillator cycle or has the wrong number of stages, because either fault moves `ready` or `reset_out` away from the phi2-rise pipeline the bench expects. SYNC pulses are placed both inside and outside the phase-2 window, and a second reset is applied mid-run. A strobe that uses the wrong SYNC sample, lasts more than one period, or does not clear after firing therefore shows up as a mismatch.

// File: rtl/twophase_clkgen_pkg.sv
package twophase_clkgen_pkg;
   // true when count c lies in the window [s, s+l)
   function automatic logic in_window(int unsigned c, int unsigned s, int unsigned l);
      return (c >= s) && (c < s + l);
   endfunction
endpackage

// File: rtl/tpc_phase_seq.sv
module tpc_phase_seq
   import twophase_clkgen_pkg::*;
#(
   parameter int unsigned DIV       = 9,
   parameter int unsigned PH1_START = 0,
   parameter int unsigned PH1_LEN   = 2,
   parameter int unsigned PH2_START = 3,
   parameter int unsigned PH2_LEN   = 5
) (
   input  logic clk,
   input  logic rst_n,
   output logic phi1_q,
   output logic phi2_q,
   output logic ph1_rise_ev,
   output logic ph2_rise_ev
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_nxt;

   always_comb begin
      if (cnt == CW'(DIV - 1)) cnt_nxt = '0;
      else                     cnt_nxt = cnt + CW'(1);
   end

   // event flags describe the edge about to happen
   assign ph1_rise_ev = (cnt_nxt == CW'(PH1_START));
   assign ph2_rise_ev = (cnt_nxt == CW'(PH2_START));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= CW'(DIV - 1);
         phi1_q <= 1'b0;
         phi2_q <= 1'b0;
      end else begin
         cnt    <= cnt_nxt;
         phi1_q <= in_window(32'(cnt_nxt), PH1_START, PH1_LEN);
         phi2_q <= in_window(32'(cnt_nxt), PH2_START, PH2_LEN);
      end
   end
endmodule

// File: rtl/tpc_edge_sync.sv
module tpc_edge_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] st;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n)  st <= RST_VAL;
            else if (en) st <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (!rst_n)  st <= {STAGES{RST_VAL}};
            else if (en) st <= {st[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/tpc_strobe_gen.sv
module tpc_strobe_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic sample_en,
   input  logic sync_in,
   input  logic fire,
   output logic strobe_n
);
   logic seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen     <= 1'b0;
         strobe_n <= 1'b1;
      end else begin
         strobe_n <= !(fire && seen);
         if (fire)                       seen <= 1'b0;
         else if (sample_en && sync_in)  seen <= 1'b1;
      end
   end
endmodule

// File: rtl/twophase_clkgen.sv
module twophase_clkgen #(
   parameter int unsigned DIV         = 9,
   parameter int unsigned PH1_START   = 0,
   parameter int unsigned PH1_LEN     = 2,
   parameter int unsigned PH2_START   = 3,
   parameter int unsigned PH2_LEN     = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic osc_clk,
   input  logic rst_n,
   input  logic rdy_in,
   input  logic resin_n,
   input  logic sync_in,
   output logic osc_out,
   output logic phi1,
   output logic phi2,
   output logic phi2_ttl,
   output logic ready,
   output logic reset_out,
   output logic stat_strobe_n
);
   localparam int unsigned PH1_END = PH1_START + PH1_LEN;
   localparam int unsigned PH2_END = PH2_START + PH2_LEN;

   // elaboration-time parameter checks
   if (DIV < 4) begin : g_bad_div
      $error("twophase_clkgen: DIV too small for two separated phases");
   end
   if (PH1_LEN == 0 || PH2_LEN == 0) begin : g_bad_len
      $error("twophase_clkgen: phase lengths must be non-zero");
   end
   if (PH1_END >= PH2_START) begin : g_bad_gap1
      $error("twophase_clkgen: no gap between phi1 and phi2");
   end
   if (PH2_END >= DIV + PH1_START) begin : g_bad_gap2
      $error("twophase_clkgen: no gap between phi2 and next phi1");
   end
   if (SYNC_STAGES == 0) begin : g_bad_sync
      $error("twophase_clkgen: at least one synchronizer stage needed");
   end

   logic ph1_rise_ev;
   logic ph2_rise_ev;

   tpc_phase_seq #(
      .DIV(DIV), .PH1_START(PH1_START), .PH1_LEN(PH1_LEN),
      .PH2_START(PH2_START), .PH2_LEN(PH2_LEN)
   ) u_seq (
      .clk(osc_clk), .rst_n(rst_n),
      .phi1_q(phi1), .phi2_q(phi2),
      .ph1_rise_ev(ph1_rise_ev), .ph2_rise_ev(ph2_rise_ev)
   );

   tpc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rdy_sync (
      .clk(osc_clk), .rst_n(rst_n), .en(ph2_rise_ev),
      .d(rdy_in), .q(ready)
   );

   tpc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_sync (
      .clk(osc_clk), .rst_n(rst_n), .en(ph2_rise_ev),
      .d(!resin_n), .q(reset_out)
   );

   tpc_strobe_gen u_stb (
      .clk(osc_clk), .rst_n(rst_n), .sample_en(phi2),
      .sync_in(sync_in), .fire(ph1_rise_ev), .strobe_n(stat_strobe_n)
   );

   assign osc_out  = osc_clk;
   assign phi2_ttl = phi2;
endmodule

// File: rtl/twophase_clkgen_chk.sv
module twophase_clkgen_chk #(
   parameter int unsigned PH1_LEN = 2,
   parameter int unsigned PH2_LEN = 5
) (
   input logic osc_clk,
   input logic rst_n,
   input logic phi1,
   input logic phi2,
   input logic phi2_ttl,
   input logic ready,
   input logic reset_out,
   input logic stat_strobe_n
);
   logic [7:0] hi1;
   logic [7:0] hi2;

   always_ff @(posedge osc_clk) begin
      if (!rst_n) begin
         hi1 <= '0;
         hi2 <= '0;
      end else begin
         hi1 <= phi1 ? hi1 + 8'd1 : 8'd0;
         hi2 <= phi2 ? hi2 + 8'd1 : 8'd0;
      end
   end

   assert_phi1_len_R1: assert property (@(posedge osc_clk) disable iff (!rst_n)
      $fell(phi1) |-> hi1 == 8'(PH1_LEN));

   assert_phi2_len_R2: assert property (@(posedge osc_clk) disable iff (!rst_n)
      $fell(phi2) |-> hi2 == 8'(PH2_LEN));

   assert_no_overlap_R3: assert property (@(posedge osc_clk) disable iff (!rst_n)
      !(phi1 && phi2));

   assert_gap_R3: assert property (@(posedge osc_clk) disable iff (!rst_n)
      $fell(phi2) |-> !phi1);

   assert_ttl_copy_R4: assert property (@(posedge osc_clk) disable iff (!rst_n)
      phi2_ttl == phi2);

   assert_ready_hold_R5: assert property (@(posedge osc_clk) disable iff (!rst_n)
      !$rose(phi2) |-> $stable(ready));

   assert_reset_hold_R6: assert property (@(posedge osc_clk) disable iff (!rst_n)
      !$rose(phi2) |-> $stable(reset_out));

   assert_strobe_place_R7: assert property (@(posedge osc_clk) disable iff (!rst_n)
      !stat_strobe_n |-> $rose(phi1));

   assert_strobe_width_R7: assert property (@(posedge osc_clk) disable iff (!rst_n)
      !stat_strobe_n |=> stat_strobe_n);
endmodule

bind twophase_clkgen twophase_clkgen_chk #(.PH1_LEN(PH1_LEN), .PH2_LEN(PH2_LEN)) u_chk (
   .osc_clk(osc_clk), .rst_n(rst_n), .phi1(phi1), .phi2(phi2),
   .phi2_ttl(phi2_ttl), .ready(ready), .reset_out(reset_out),
   .stat_strobe_n(stat_strobe_n)
);

// File: tb/test_twophase_clkgen.sv
`timescale 1ns/1ps
module test_twophase_clkgen;
   logic osc_clk = 1'b0;
   logic rst_n   = 1'b0;
   logic rdy_in  = 1'b0;
   logic resin_n = 1'b1;
   logic sync_in = 1'b0;
   logic osc_out, phi1, phi2, phi2_ttl, ready, reset_out, stat_strobe_n;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #5 osc_clk = ~osc_clk;   // 100 MHz

   twophase_clkgen i_twophase_clkgen (
      .osc_clk(osc_clk), .rst_n(rst_n), .rdy_in(rdy_in), .resin_n(resin_n),
      .sync_in(sync_in), .osc_out(osc_out), .phi1(phi1), .phi2(phi2),
      .phi2_ttl(phi2_ttl), .ready(ready), .reset_out(reset_out),
      .stat_strobe_n(stat_strobe_n)
   );

   // expected behaviour from the requirements
   function automatic bit exp_phi1(int k); return (k >= 0) && (k < 2); endfunction
   function automatic bit exp_phi2(int k); return (k >= 3) && (k < 8); endfunction

   int k = 8;           // phase position after the last edge
   bit m_seen = 0, m_stb_n = 1;
   bit m_r1 = 0, m_rdy = 0, m_x1 = 1, m_rst = 1;

   always @(posedge osc_clk) begin
      int kn;
      if (!rst_n) begin
         k = 8; m_seen = 0; m_stb_n = 1;
         m_r1 = 0; m_rdy = 0; m_x1 = 1; m_rst = 1;
      end else begin
         kn = (k + 1) % 9;
         m_stb_n = !(kn == 0 && m_seen);
         if (kn == 0) m_seen = 0;
         else if (exp_phi2(k) && sync_in) m_seen = 1;
         if (kn == 3) begin
            m_rdy = m_r1; m_r1 = rdy_in;
            m_rst = m_x1; m_x1 = !resin_n;
         end
         k = kn;
      end
   end

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
      end
   endtask

   // compare at the falling edge, away from the active edge
   realtime last_rise = -1;
   bit prev_phi1 = 0;
   always @(negedge osc_clk) begin
      if (!done) begin
         if (!rst_n) begin
            chk(phi1 == 0 && phi2 == 0, "R8 phases idle in reset", {phi1, phi2}, 0);
            chk(ready == 0 && reset_out == 1 && stat_strobe_n == 1,
                "R8 outputs in reset", {ready, reset_out, stat_strobe_n}, 3'b011);
            last_rise = -1;
         end else begin
            chk(phi1 == exp_phi1(k), "R1 phi1 window", phi1, exp_phi1(k));
            chk(phi2 == exp_phi2(k), "R2 phi2 window", phi2, exp_phi2(k));
            chk(!(phi1 && phi2), "R3 overlap", {phi1, phi2}, 0);
            if (phi1 && !prev_phi1) begin
               if (last_rise >= 0)
                  chk($realtime - last_rise == 90.0, "R1 phi1 period",
                      int'($realtime - last_rise), 90);
               last_rise = $realtime;
            end
            chk(ready == m_rdy, "R5 ready", ready, m_rdy);
            chk(reset_out == m_rst, "R6 reset_out", reset_out, m_rst);
            chk(stat_strobe_n == m_stb_n, "R7 status strobe", stat_strobe_n, m_stb_n);
         end
         chk(phi2_ttl == phi2 && osc_out == 1'b0, "R4 copies",
             {phi2_ttl, osc_out}, {phi2, 1'b0});
         prev_phi1 = phi1;
      end
   end

   // osc_out checked high in the high half too
   always @(posedge osc_clk) begin
      #1;
      if (!done) chk(osc_out == 1'b1, "R4 osc_out high", osc_out, 1);
   end

   task automatic step(int n);
      repeat (n) @(negedge osc_clk);
      #1;
   endtask

   initial begin
      void'($urandom(32'd4711));
      step(4);
      rst_n = 1'b1;                  // R8: first edge gives phi1
      step(20);
      // directed R7: sync only during phi1 window, expect no strobe
      for (int i = 0; i < 30; i++) begin
         sync_in = exp_phi1((k + 1) % 9);
         step(1);
      end
      sync_in = 1'b0;
      // directed R5/R6: single level changes
      rdy_in = 1'b1; step(30);
      resin_n = 1'b0; step(30);
      resin_n = 1'b1; rdy_in = 1'b0; step(30);
      // random phase
      for (int i = 0; i < 2000; i++) begin
         if ($urandom_range(7) == 0) rdy_in = ~rdy_in;
         if ($urandom_range(15) == 0) resin_n = ~resin_n;
         sync_in = ($urandom_range(2) == 0);
         if (i == 1000) begin
            rst_n = 1'b0; step(3); rst_n = 1'b1;   // R8 mid-run reset
         end
         step(1);
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule